// File: doc/BRIEF.md
# Flash Row Program Sequencer

This block sits on the host side of a byte-wide flash register bank. The bank is reached through a 3-bit register select, an 8-bit write data path with a write strobe, and an 8-bit read-back path. The sequencer takes one command at a time over a valid/ready handshake. A command carries a read/program flag, a 16-bit start address and a byte count. The block then issues the register writes and timed pauses that the flash needs to program a run of bytes inside one 64-byte row, or to read a run of bytes back.

When programming, the row-level program and store controls stay asserted for the whole run. Only the column strobe is pulsed once per byte, and only the low address byte moves between bytes. Data bytes arrive on their own valid/ready input. Read bytes leave on a valid/ready output. Every pause is a number of clock cycles derived from a clock-frequency parameter in MHz. The total time the column strobe is held high in one row is accumulated against a high-voltage budget, and the run is ended early with an error if the next byte would exceed that budget. Page erase, mass erase and debugger entry are left to other logic.

Top module: `flash_row_seq`

## Requirements
- R1: After reset, busy, done, bank_we, wr_ready and rd_valid are 0 and cmd_ready is 1.
- R2: Every accepted command that passes the span check starts with one write of 0x80 to select 4, which sets the test-mode bit.
- R3: A program command continues with these writes: address bits 15:8 to select 0, address bits 7:0 to select 1, then 0x84 to select 3. This is followed by a pause of XP_SETUP_US, then 0x85 to select 3, then a pause of NV_SETUP_US before the first byte. Select 3 bits, from bit 7 down: row enable, column enable, sense enable, output enable, erase, program, mass select, store.
- R4: For each program byte the block writes the current low address to select 1. It then takes one data byte from the wr handshake and writes it to select 2, writes 0xC5 to select 3, holds for YE_HOLD_US, and writes 0x85 to select 3. The low address advances by one per byte and select 0 is not written again.
- R5: After the last byte the block writes 0x81 to select 3, pauses PG_HOLD_US, writes 0x00 to select 3, pauses RECOVER_US, then pulses done.
- R6: A read command writes 0x80 to select 4, the high address to select 0, the low address to select 1, and 0xF0 to select 3. For each byte it then drives select 5 without a write strobe, samples bank_rdata one cycle later and offers the byte on rd_data. Between bytes it writes the next low address to select 1. It ends with 0x00 to select 3. Select 5 is never written.
- R7: A command with a count of 0, or one where address bits 5:0 plus the count exceed 64, is rejected. The block makes no bank write, takes no data byte, and pulses done with err_flag at 1.
- R8: Before each program byte, if the accumulated column-high time plus one more hold would exceed HV_BUDGET_US, the block makes no further column pulse. It runs the R5 closing writes and reports err_flag at 1 with done. A run that exactly reaches the budget completes with err_flag at 0.
- R9: busy rises the cycle after a command is accepted. done is a one-cycle pulse after which busy is 0. err_flag is valid while done is 1.
- R10: While rd_valid is 1 and rd_ready is 0, rd_valid stays 1 and rd_data stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken when high with cmd_valid |
| cmd_read | input | 1 | 1 = read run, 0 = program run |
| cmd_addr | input | 16 | Start byte address |
| cmd_len | input | 7 | Number of bytes, 1 to 64 |
| wr_valid | input | 1 | Program data byte offered |
| wr_ready | output | 1 | Program data byte taken |
| wr_data | input | 8 | Program data byte |
| rd_valid | output | 1 | Read byte offered |
| rd_ready | input | 1 | Read byte taken |
| rd_data | output | 8 | Read byte |
| bank_sel | output | 3 | Register bank select |
| bank_wdata | output | 8 | Register bank write data |
| bank_we | output | 1 | Register bank write strobe |
| bank_rdata | input | 8 | Register bank read-back |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err_flag | output | 1 | Last command rejected or aborted |

## Verification
Two decisions can meet in one cycle: the budget test made at the start of a byte, and the end of the run. They coincide when the last byte of a run brings the accumulated column-high time exactly to the budget. A three-byte run sized to fill the budget exactly must finish cleanly. A five-byte run must stop before its fourth strobe and close the row with err_flag set. The row-span check is probed the same way, with a run that ends exactly on the row's last column and one that overruns it by a single byte. Each case is judged by the exact stream of bank writes, the spacing between the timed writes, and the err_flag reported with done.

// File: rtl/frs_pkg.sv
package frs_pkg;

  // register bank select codes
  localparam logic [2:0] SEL_ROW_HI = 3'd0;
  localparam logic [2:0] SEL_ROW_LO = 3'd1;
  localparam logic [2:0] SEL_DIN    = 3'd2;
  localparam logic [2:0] SEL_CTL    = 3'd3;
  localparam logic [2:0] SEL_AUX    = 3'd4;
  localparam logic [2:0] SEL_DOUT   = 3'd5;

  // control values (select 3) and test-mode value (select 4)
  localparam logic [7:0] AUX_TMR      = 8'h80;
  localparam logic [7:0] CTL_PROG_X   = 8'h84;
  localparam logic [7:0] CTL_PROG_NV  = 8'h85;
  localparam logic [7:0] CTL_PROG_YE  = 8'hC5;
  localparam logic [7:0] CTL_PROG_END = 8'h81;
  localparam logic [7:0] CTL_IDLE     = 8'h00;
  localparam logic [7:0] CTL_READ     = 8'hF0;

  typedef enum logic [4:0] {
    ST_IDLE, ST_TMR, ST_AHI, ST_ALO, ST_MODE, ST_WAIT, ST_NVON,
    ST_BLO, ST_BDAT, ST_YEON, ST_YEOFF, ST_PDN, ST_OFF,
    ST_RSEL, ST_RCAP, ST_RHOLD, ST_RNEXT, ST_REND, ST_DONE
  } frs_state_e;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/frs_wait_timer.sv
module frs_wait_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/frs_hv_meter.sv
module frs_hv_meter #(
  parameter  int YE_CYC     = 600,
  parameter  int BUDGET_CYC = 240000,
  localparam int ACC_W      = $clog2(BUDGET_CYC + 2 * YE_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic add,
  output logic over_next
);

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W:0]   sum_next;

  always_comb begin
    acc_d = acc_q;
    if (clr)
      acc_d = '0;
    else if (add)
      acc_d = acc_q + ACC_W'(YE_CYC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign sum_next  = {1'b0, acc_q} + (ACC_W + 1)'(YE_CYC);
  assign over_next = (sum_next > (ACC_W + 1)'(BUDGET_CYC));

endmodule

// File: rtl/frs_span_check.sv
module frs_span_check #(
  parameter  int ROW_BYTES = 64,
  localparam int COL_W     = $clog2(ROW_BYTES),
  localparam int LEN_W     = COL_W + 1
) (
  input  logic [COL_W-1:0] col,
  input  logic [LEN_W-1:0] len,
  output logic             ok
);

  logic [LEN_W:0] span_end;

  assign span_end = {2'b00, col} + {1'b0, len};
  assign ok       = (len != '0) && (span_end <= (LEN_W + 1)'(ROW_BYTES));

endmodule

// File: rtl/flash_row_seq.sv
module flash_row_seq
  import frs_pkg::*;
#(
  parameter  int CLK_MHZ      = 20,
  parameter  int ROW_BYTES    = 64,
  parameter  int XP_SETUP_US  = 5,
  parameter  int NV_SETUP_US  = 10,
  parameter  int YE_HOLD_US   = 30,
  parameter  int PG_HOLD_US   = 5,
  parameter  int RECOVER_US   = 1,
  parameter  int HV_BUDGET_US = 12000,
  localparam int LEN_W        = $clog2(ROW_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_read,
  input  logic [15:0]      cmd_addr,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic [2:0]       bank_sel,
  output logic [7:0]       bank_wdata,
  output logic             bank_we,
  input  logic [7:0]       bank_rdata,
  output logic             busy,
  output logic             done,
  output logic             err_flag
);

  localparam int COL_W      = $clog2(ROW_BYTES);
  localparam int XP_CYC     = XP_SETUP_US * CLK_MHZ;
  localparam int NV_CYC     = NV_SETUP_US * CLK_MHZ;
  localparam int YE_CYC     = YE_HOLD_US * CLK_MHZ;
  localparam int PG_CYC     = PG_HOLD_US * CLK_MHZ;
  localparam int RC_CYC     = RECOVER_US * CLK_MHZ;
  localparam int BUDGET_CYC = HV_BUDGET_US * CLK_MHZ;
  localparam int WAIT_MAX   = imax(imax(imax(XP_CYC, NV_CYC), imax(YE_CYC, PG_CYC)), RC_CYC);
  localparam int WT_W       = $clog2(WAIT_MAX + 1);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // state
  frs_state_e       state_q, state_d, ret_q, ret_d;
  logic [7:0]       hi_q, hi_d, lo_q, lo_d, rdat_q, rdat_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic             read_q, read_d, err_q, err_d;

  // helper controls
  logic            tmr_load, tmr_zero;
  logic [WT_W-1:0] tmr_val;
  logic            hv_clr, hv_add, hv_over;
  logic            span_ok;

  frs_wait_timer #(.W(WT_W)) i_wait_timer (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  frs_hv_meter #(.YE_CYC(YE_CYC), .BUDGET_CYC(BUDGET_CYC)) i_hv_meter (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .clr       (hv_clr),
    .add       (hv_add),
    .over_next (hv_over)
  );

  frs_span_check #(.ROW_BYTES(ROW_BYTES)) i_span_check (
    .col (cmd_addr[COL_W-1:0]),
    .len (cmd_len),
    .ok  (span_ok)
  );

  // next-state logic
  always_comb begin
    state_d    = state_q;
    ret_d      = ret_q;
    hi_d       = hi_q;
    lo_d       = lo_q;
    rem_d      = rem_q;
    read_d     = read_q;
    err_d      = err_q;
    rdat_d     = rdat_q;
    bank_we    = 1'b0;
    bank_sel   = SEL_ROW_HI;
    bank_wdata = 8'h00;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    hv_clr     = 1'b0;
    hv_add     = 1'b0;
    cmd_ready  = 1'b0;
    wr_ready   = 1'b0;

    case (state_q)
      ST_IDLE: begin
        cmd_ready = 1'b1;
        if (cmd_valid) begin
          hi_d   = cmd_addr[15:8];
          lo_d   = cmd_addr[7:0];
          rem_d  = cmd_len;
          read_d = cmd_read;
          hv_clr = 1'b1;
          err_d  = !span_ok;
          state_d = span_ok ? ST_TMR : ST_DONE;
        end
      end
      ST_TMR: begin
        bank_we = 1'b1; bank_sel = SEL_AUX; bank_wdata = AUX_TMR;
        state_d = ST_AHI;
      end
      ST_AHI: begin
        bank_we = 1'b1; bank_sel = SEL_ROW_HI; bank_wdata = hi_q;
        state_d = ST_ALO;
      end
      ST_ALO: begin
        bank_we = 1'b1; bank_sel = SEL_ROW_LO; bank_wdata = lo_q;
        state_d = ST_MODE;
      end
      ST_MODE: begin
        bank_we  = 1'b1;
        bank_sel = SEL_CTL;
        if (read_q) begin
          bank_wdata = CTL_READ;
          state_d    = ST_RSEL;
        end else begin
          bank_wdata = CTL_PROG_X;
          tmr_load   = 1'b1;
          tmr_val    = WT_W'(XP_CYC - 1);
          ret_d      = ST_NVON;
          state_d    = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (tmr_zero) state_d = ret_q;
      end
      ST_NVON: begin
        bank_we = 1'b1; bank_sel = SEL_CTL; bank_wdata = CTL_PROG_NV;
        tmr_load = 1'b1;
        tmr_val  = WT_W'(NV_CYC - 1);
        ret_d    = ST_BLO;
        state_d  = ST_WAIT;
      end
      ST_BLO: begin
        if (hv_over) begin
          err_d   = 1'b1;
          state_d = ST_PDN;
        end else begin
          bank_we = 1'b1; bank_sel = SEL_ROW_LO; bank_wdata = lo_q;
          state_d = ST_BDAT;
        end
      end
      ST_BDAT: begin
        wr_ready = 1'b1;
        if (wr_valid) begin
          bank_we = 1'b1; bank_sel = SEL_DIN; bank_wdata = wr_data;
          state_d = ST_YEON;
        end
      end
      ST_YEON: begin
        bank_we = 1'b1; bank_sel = SEL_CTL; bank_wdata = CTL_PROG_YE;
        hv_add   = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = WT_W'(YE_CYC - 1);
        ret_d    = ST_YEOFF;
        state_d  = ST_WAIT;
      end
      ST_YEOFF: begin
        bank_we = 1'b1; bank_sel = SEL_CTL; bank_wdata = CTL_PROG_NV;
        rem_d = rem_q - LEN_W'(1);
        lo_d  = lo_q + 8'd1;
        state_d = (rem_q == LEN_W'(1)) ? ST_PDN : ST_BLO;
      end
      ST_PDN: begin
        bank_we = 1'b1; bank_sel = SEL_CTL; bank_wdata = CTL_PROG_END;
        tmr_load = 1'b1;
        tmr_val  = WT_W'(PG_CYC - 1);
        ret_d    = ST_OFF;
        state_d  = ST_WAIT;
      end
      ST_OFF: begin
        bank_we = 1'b1; bank_sel = SEL_CTL; bank_wdata = CTL_IDLE;
        tmr_load = 1'b1;
        tmr_val  = WT_W'(RC_CYC - 1);
        ret_d    = ST_DONE;
        state_d  = ST_WAIT;
      end
      ST_RSEL: begin
        bank_sel = SEL_DOUT;
        state_d  = ST_RCAP;
      end
      ST_RCAP: begin
        bank_sel = SEL_DOUT;
        rdat_d   = bank_rdata;
        state_d  = ST_RHOLD;
      end
      ST_RHOLD: begin
        if (rd_ready) begin
          rem_d = rem_q - LEN_W'(1);
          lo_d  = lo_q + 8'd1;
          state_d = (rem_q == LEN_W'(1)) ? ST_REND : ST_RNEXT;
        end
      end
      ST_RNEXT: begin
        bank_we = 1'b1; bank_sel = SEL_ROW_LO; bank_wdata = lo_q;
        state_d = ST_RSEL;
      end
      ST_REND: begin
        bank_we = 1'b1; bank_sel = SEL_CTL; bank_wdata = CTL_IDLE;
        state_d = ST_DONE;
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_IDLE;
      ret_q   <= ST_IDLE;
      hi_q    <= 8'h00;
      lo_q    <= 8'h00;
      rem_q   <= '0;
      read_q  <= 1'b0;
      err_q   <= 1'b0;
      rdat_q  <= 8'h00;
    end else begin
      state_q <= state_d;
      ret_q   <= ret_d;
      hi_q    <= hi_d;
      lo_q    <= lo_d;
      rem_q   <= rem_d;
      read_q  <= read_d;
      err_q   <= err_d;
      rdat_q  <= rdat_d;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = (state_q == ST_DONE);
  assign rd_valid = (state_q == ST_RHOLD);
  assign rd_data  = rdat_q;
  assign err_flag = err_q;

endmodule

// File: rtl/frs_checker.sv
module frs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       wr_ready,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic [2:0] bank_sel,
  input logic       bank_we,
  input logic       busy,
  input logic       done
);

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> busy);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  // R6
  no_dout_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |-> (bank_sel != 3'd5));

  // R4
  wr_in_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> busy && !rd_valid && !done);

  // R2
  write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |-> busy && !cmd_ready);

endmodule

bind flash_row_seq frs_checker i_frs_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .wr_ready  (wr_ready),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_data   (rd_data),
  .bank_sel  (bank_sel),
  .bank_we   (bank_we),
  .busy      (busy),
  .done      (done)
);

// File: tb/test_flash_row_seq.sv
module test_flash_row_seq;

  localparam int MHZ  = 2;
  localparam int XP_G = 5 * MHZ + 1;
  localparam int NV_G = 10 * MHZ + 1;
  localparam int YE_G = 30 * MHZ + 1;
  localparam int PG_G = 5 * MHZ + 1;

  logic       clk;
  logic       rst_n;
  logic       cmd_valid, cmd_ready, cmd_read;
  logic [15:0] cmd_addr;
  logic [6:0] cmd_len;
  logic       wr_valid, wr_ready;
  logic [7:0] wr_data;
  logic       rd_valid, rd_ready;
  logic [7:0] rd_data;
  logic [2:0] bank_sel;
  logic [7:0] bank_wdata, bank_rdata;
  logic       bank_we, busy, done, err_flag;

  int checks;
  int errors;
  int cyc;
  int last_we;
  int wr_seen;
  logic [7:0] m_hi, m_lo;

  int          q_sel[$];
  logic [7:0]  q_dat[$];
  int          q_gap[$];
  string       q_req[$];
  logic [7:0]  q_rd[$];

  flash_row_seq #(.CLK_MHZ(MHZ), .HV_BUDGET_US(90)) i_flash_row_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_read(cmd_read),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .bank_sel(bank_sel), .bank_wdata(bank_wdata), .bank_we(bank_we),
    .bank_rdata(bank_rdata),
    .busy(busy), .done(done), .err_flag(err_flag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] mem_fn(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [7:0] dat_fn(logic [15:0] a, int i);
    return 8'(a[7:0] + 8'(i)) ^ 8'h96;
  endfunction

  assign bank_rdata = mem_fn({m_hi, m_lo});

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push_w(input int sel, input logic [7:0] d, input int gap, input string req);
    q_sel.push_back(sel);
    q_dat.push_back(d);
    q_gap.push_back(gap);
    q_req.push_back(req);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    cyc++;
    if (rst_n && bank_we) begin
      if (q_sel.size() == 0) begin
        chk(1'b0, "R7", "unexpected bank write sel", 32'(bank_sel), 32'hFF);
      end else begin
        int es;
        logic [7:0] ed;
        int eg;
        string er;
        es = q_sel.pop_front();
        ed = q_dat.pop_front();
        eg = q_gap.pop_front();
        er = q_req.pop_front();
        chk(32'(bank_sel) == es && bank_wdata == ed, er, "bank write {sel,data}",
            {21'd0, bank_sel, bank_wdata}, 32'((es << 8) | int'(ed)));
        if (eg >= 0)
          chk(cyc - last_we == eg, er, "spacing after previous write",
              32'(cyc - last_we), 32'(eg));
      end
      if (bank_sel == 3'd0) m_hi <= bank_wdata;
      if (bank_sel == 3'd1) m_lo <= bank_wdata;
      last_we = cyc;
    end
    if (rst_n && rd_valid && rd_ready) begin
      if (q_rd.size() == 0)
        chk(1'b0, "R6", "unexpected read byte", 32'(rd_data), 32'hFFF);
      else begin
        logic [7:0] er8;
        er8 = q_rd.pop_front();
        chk(rd_data == er8, "R6", "read byte", 32'(rd_data), 32'(er8));
      end
    end
    if (rst_n && wr_ready) wr_seen++;
  end

  task automatic send_cmd(input bit rd, input logic [15:0] a, input int n);
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_read = rd; cmd_addr = a; cmd_len = 7'(n);
    do @(negedge clk); while (!cmd_ready);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic finish_cmd(input bit exp_err, input string req);
    do @(negedge clk); while (!done);
    chk(err_flag == exp_err, req, "err_flag with done", 32'(err_flag), 32'(exp_err));
    @(negedge clk);
    chk(!busy && cmd_ready, "R9", "idle after done", {30'd0, busy, cmd_ready}, 32'h1);
    chk(q_sel.size() == 0, req, "bank writes left unseen", 32'(q_sel.size()), 32'h0);
    chk(q_rd.size() == 0, req, "read bytes left unseen", 32'(q_rd.size()), 32'h0);
  endtask

  // n requested bytes, k bytes expected to be programmed
  task automatic run_prog(input logic [15:0] a, input int n, input int k,
                          input bit exp_err, input string req);
    push_w(4, 8'h80, -1, "R2");
    push_w(0, a[15:8], -1, "R3");
    push_w(1, a[7:0], -1, "R3");
    push_w(3, 8'h84, -1, "R3");
    push_w(3, 8'h85, XP_G, "R3");
    for (int i = 0; i < k; i++) begin
      push_w(1, 8'(a[7:0] + 8'(i)), (i == 0) ? NV_G : -1, "R4");
      push_w(2, dat_fn(a, i), -1, "R4");
      push_w(3, 8'hC5, -1, "R4");
      push_w(3, 8'h85, YE_G, "R4");
    end
    push_w(3, 8'h81, -1, "R5");
    push_w(3, 8'h00, PG_G, "R5");
    wr_seen = 0;
    send_cmd(1'b0, a, n);
    for (int i = 0; i < k; i++) begin
      @(posedge clk); #1;
      wr_valid = 1'b1; wr_data = dat_fn(a, i);
      do @(negedge clk); while (!wr_ready);
      @(posedge clk); #1;
      wr_valid = 1'b0;
    end
    finish_cmd(exp_err, req);
    chk(wr_seen == k, req, "data bytes taken", 32'(wr_seen), 32'(k));
  endtask

  task automatic run_reject(input logic [15:0] a, input int n);
    wr_seen = 0;
    wr_valid = 1'b1; wr_data = 8'h55;
    send_cmd(1'b0, a, n);
    finish_cmd(1'b1, "R7");
    wr_valid = 1'b0;
    chk(wr_seen == 0, "R7", "data taken on rejected command", 32'(wr_seen), 32'h0);
  endtask

  task automatic run_read(input logic [15:0] a, input int n, input int stall);
    push_w(4, 8'h80, -1, "R2");
    push_w(0, a[15:8], -1, "R6");
    push_w(1, a[7:0], -1, "R6");
    push_w(3, 8'hF0, -1, "R6");
    for (int i = 1; i < n; i++) push_w(1, 8'(a[7:0] + 8'(i)), -1, "R6");
    push_w(3, 8'h00, -1, "R6");
    for (int i = 0; i < n; i++) q_rd.push_back(mem_fn({a[15:8], 8'(a[7:0] + 8'(i))}));
    send_cmd(1'b1, a, n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d0;
      do @(negedge clk); while (!rd_valid);
      d0 = rd_data;
      repeat (stall) @(negedge clk);
      chk(rd_valid && rd_data == d0, "R10", "held read byte", {23'd0, rd_valid, rd_data},
          {23'd1, 1'b1, d0});
      @(posedge clk); #1;
      rd_ready = 1'b1;
      @(posedge clk); #1;
      rd_ready = 1'b0;
    end
    finish_cmd(1'b0, "R6");
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R9", "watchdog expired", 32'(cyc), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0; cyc = 0; last_we = 0; wr_seen = 0;
    m_hi = 8'h00; m_lo = 8'h00;
    rst_n = 1'b0;
    cmd_valid = 1'b0; cmd_read = 1'b0; cmd_addr = 16'h0; cmd_len = 7'd0;
    wr_valid = 1'b0; wr_data = 8'h0; rd_ready = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!busy && !done, "R1", "busy/done after reset", {30'd0, busy, done}, 32'h0);
    chk(!bank_we, "R1", "bank_we after reset", 32'(bank_we), 32'h0);
    chk(!wr_ready && !rd_valid, "R1", "wr_ready/rd_valid after reset",
        {30'd0, wr_ready, rd_valid}, 32'h0);
    chk(cmd_ready, "R1", "cmd_ready after reset", 32'(cmd_ready), 32'h1);

    // R3 R4 R5: three bytes exactly filling the budget (R8 boundary)
    run_prog(16'h1234, 3, 3, 1'b0, "R8");
    // R4 run ending on the last column of the row
    run_prog(16'h0A3D, 3, 3, 1'b0, "R4");
    // R7 one byte past the row end, and a zero count
    run_reject(16'h0A3D, 4);
    run_reject(16'h4410, 0);
    // R8 budget runs out before the fourth byte
    run_prog(16'h2200, 5, 3, 1'b1, "R8");
    // R6 R10 reads with and without back-pressure
    run_read(16'h5578, 4, 3);
    run_read(16'h0001, 1, 0);
    // R5 single byte program after a read
    run_prog(16'hBEEF, 1, 1, 1'b0, "R5");

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule